// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the run, idle and power-down states of a small 8-bit microcontroller. Software raises a request for idle or for power-down. Enabled interrupt requests arrive on two lines, one from on-chip peripherals and one from external pins. A functional hardware reset can also arrive. From these inputs the block drives the clock enables for the CPU core and for the peripherals, the oscillator enable, a write-inhibit for internal RAM and a one-cycle strobe that resets the special-function registers. It also sets the levels of the address-latch and program-store strobe pins.

The block runs on the raw input clock. A toggle flip-flop halves that clock, and all core and peripheral enables are qualified by its output, so the internal clock does not depend on the duty cycle of the input. RAM and register contents stay under the control of the core. The block only gates clocks and writes, so state survives both low-power modes.

Three cases need extra steps:
- A power-down ended by an external interrupt waits for an oscillator-settling count before the CPU restarts.
- An idle ended by a hardware reset lets the CPU run on for a fixed number of machine cycles with RAM writes blocked. The register-reset strobe then fires.
- If both requests arrive in the same cycle, power-down wins.

Top module: `lpm_ctrl`

## Requirements
- R1: In run mode `periph_clk_en` is high on every second raw clock cycle and low on the others (divide-by-two of the input clock).
- R2: A pulse on `req_idle` alone enters idle. In idle, `cpu_clk_en` stays 0, `periph_clk_en` keeps toggling, `osc_en` is 1 and `mode_bits` reads 2'b01 (bit 0 = idle, bit 1 = power-down).
- R3: Idle returns to run on `irq_int` or on `irq_ext`, and `mode_bits` reads 2'b00 afterwards.
- R4: A pulse on `req_pd` enters power-down. In power-down, `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 0 and `mode_bits` reads 2'b10.
- R5: In power-down `irq_int` has no effect: `mode_bits` stays 2'b10 and `osc_en` stays 0.
- R6: `irq_ext` in power-down raises `osc_en` at once. The CPU then stays stopped for exactly `STAB_CYCLES` raw clocks, with the strobe pins held low, before run mode resumes.
- R7: A rising edge of `hw_reset` in power-down returns to run at the next clock edge and pulses `sfr_reset` for exactly one cycle.
- R8: The strobe pins follow `core_ale`/`core_psen` in run mode. Both are driven 1 in idle, and both are driven 0 in power-down and during oscillator settling.
- R9: A rising edge of `hw_reset` in idle gives exactly `RST_WIN_MC`×`MC_TICKS` internal clock ticks (24 by default) with `cpu_clk_en` and `ram_wr_inhibit` both high. One `sfr_reset` pulse follows, then run mode with `ram_wr_inhibit` at 0.
- R10: If `req_idle` and `req_pd` arrive in the same cycle, power-down is entered (`mode_bits` = 2'b10). Both mode bits read 0 after the exit.
- R11: A rising edge of `hw_reset` in run mode gives exactly one `sfr_reset` pulse, and the block stays in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Raw input clock |
| rst_n | input | 1 | Power-on reset of this block, active low |
| req_idle | input | 1 | Software request to enter idle |
| req_pd | input | 1 | Software request to enter power-down |
| irq_int | input | 1 | Enabled interrupt from an on-chip peripheral |
| irq_ext | input | 1 | Enabled interrupt from an external pin |
| hw_reset | input | 1 | Functional hardware reset, edge-detected |
| core_ale | input | 1 | Address-latch strobe from the core in run mode |
| core_psen | input | 1 | Program-store strobe from the core in run mode |
| cpu_clk_en | output | 1 | Clock enable for the CPU core |
| periph_clk_en | output | 1 | Clock enable for the peripherals |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| sfr_reset | output | 1 | One-cycle special-function register reset strobe |
| pin_ale | output | 1 | Address-latch strobe pin level |
| pin_psen | output | 1 | Program-store strobe pin level |
| mode_bits | output | 2 | Mode bits {power-down, idle} |

## Verification
The bench pulses a peripheral interrupt during power-down. A design that accepts any interrupt as a wake source would leave power-down, and the bench would see `mode_bits` change. It counts the raw clocks of oscillator settling and the internal ticks of the idle-reset window, so an off-by-one counter shows up as a wrong count. A design that starts the CPU too early, or drops the RAM inhibit too soon, also changes these counts. It raises both requests together to catch a design that gives idle precedence. It sets the core strobe inputs to values that differ from the idle and power-down pin levels, so a design that passes them through in a low-power mode gives wrong pin levels.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_IDLE = 3'd1,
        ST_PD   = 3'd2,
        ST_STAB = 3'd3,
        ST_RWIN = 3'd4
    } lpm_state_e;
endpackage

// File: rtl/lpm_clkdiv.sv
module lpm_clkdiv (
    input  logic clk_in,
    input  logic rst_n,
    output logic tick
);
    logic div_d, div_q;

    always_comb begin
        div_d = ~div_q;
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= div_d;
    end

    assign tick = div_q;

    AST_TICK_ALT: assert property (@(posedge clk_in) disable iff (!rst_n)
        tick |=> !tick);  // R1
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int STAB_CYCLES = 1024,
    parameter int MC_TICKS    = 12,
    parameter int RST_WIN_MC  = 2
) (
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       req_idle,
    input  logic       req_pd,
    input  logic       irq_int,
    input  logic       irq_ext,
    input  logic       hw_reset,
    output lpm_state_e state,
    output logic       sfr_pulse
);
    localparam int SW = $clog2(STAB_CYCLES + 1);
    localparam int TW = (MC_TICKS > 1) ? $clog2(MC_TICKS) : 1;
    localparam int MW = (RST_WIN_MC > 1) ? $clog2(RST_WIN_MC) : 1;

    typedef struct packed {
        lpm_state_e    state;
        logic [SW-1:0] cnt;
        logic [TW-1:0] tk;
        logic [MW-1:0] mc;
        logic          rst_prev;
        logic          sfr;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      rst_rise;

    always_comb begin
        r_d          = r_q;
        r_d.rst_prev = hw_reset;
        r_d.sfr      = 1'b0;
        rst_rise     = hw_reset & ~r_q.rst_prev;
        case (r_q.state)
            ST_RUN: begin
                if (rst_rise)      r_d.sfr   = 1'b1;
                else if (req_pd)   r_d.state = ST_PD;
                else if (req_idle) r_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (rst_rise) begin
                    r_d.state = ST_RWIN;
                    r_d.tk    = '0;
                    r_d.mc    = '0;
                end else if (irq_int || irq_ext) begin
                    r_d.state = ST_RUN;
                end
            end
            ST_PD: begin
                if (rst_rise) begin
                    r_d.state = ST_RUN;
                    r_d.sfr   = 1'b1;
                end else if (irq_ext) begin
                    r_d.state = ST_STAB;
                    r_d.cnt   = SW'(STAB_CYCLES - 1);
                end
            end
            ST_STAB: begin
                if (r_q.cnt == '0) r_d.state = ST_RUN;
                else               r_d.cnt   = r_q.cnt - 1'b1;
            end
            ST_RWIN: begin
                if (tick) begin
                    if (r_q.tk == TW'(MC_TICKS - 1)) begin
                        r_d.tk = '0;
                        if (r_q.mc == MW'(RST_WIN_MC - 1)) begin
                            r_d.state = ST_RUN;
                            r_d.sfr   = 1'b1;
                        end else begin
                            r_d.mc = r_q.mc + 1'b1;
                        end
                    end else begin
                        r_d.tk = r_q.tk + 1'b1;
                    end
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_RUN;
            r_q.cnt      <= '0;
            r_q.tk       <= '0;
            r_q.mc       <= '0;
            r_q.rst_prev <= 1'b0;
            r_q.sfr      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.state;
    assign sfr_pulse = r_q.sfr;

    AST_PD_INT_IGNORED: assert property (@(posedge clk_in) disable iff (!rst_n)
        (r_q.state == ST_PD && !irq_ext && !rst_rise) |=> r_q.state == ST_PD);  // R5
    AST_STAB_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
        (r_q.state == ST_STAB && r_q.cnt != '0) |=> r_q.state == ST_STAB);  // R6
    AST_SFR_SINGLE: assert property (@(posedge clk_in) disable iff (!rst_n)
        r_q.sfr |=> !r_q.sfr);  // R11
    AST_RWIN_FROM_IDLE: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(r_q.state == ST_RWIN) |-> $past(r_q.state) == ST_IDLE);  // R9
    AST_PD_PRIORITY: assert property (@(posedge clk_in) disable iff (!rst_n)
        (r_q.state == ST_RUN && req_pd && !rst_rise) |=> r_q.state == ST_PD);  // R10
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int STAB_CYCLES = 1024,
    parameter int MC_TICKS    = 12,
    parameter int RST_WIN_MC  = 2
) (
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic       req_idle,
    input  logic       req_pd,
    input  logic       irq_int,
    input  logic       irq_ext,
    input  logic       hw_reset,
    input  logic       core_ale,
    input  logic       core_psen,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       osc_en,
    output logic       ram_wr_inhibit,
    output logic       sfr_reset,
    output logic       pin_ale,
    output logic       pin_psen,
    output logic [1:0] mode_bits
);
    logic       tick;
    lpm_state_e state;

    lpm_clkdiv u_div (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .tick   (tick)
    );

    lpm_fsm #(
        .STAB_CYCLES (STAB_CYCLES),
        .MC_TICKS    (MC_TICKS),
        .RST_WIN_MC  (RST_WIN_MC)
    ) u_fsm (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .tick      (tick),
        .req_idle  (req_idle),
        .req_pd    (req_pd),
        .irq_int   (irq_int),
        .irq_ext   (irq_ext),
        .hw_reset  (hw_reset),
        .state     (state),
        .sfr_pulse (sfr_reset)
    );

    always_comb begin
        cpu_clk_en     = tick && (state == ST_RUN || state == ST_RWIN);
        periph_clk_en  = tick && (state == ST_RUN || state == ST_IDLE || state == ST_RWIN);
        osc_en         = (state != ST_PD);
        ram_wr_inhibit = (state == ST_RWIN);
        mode_bits      = {state == ST_PD, state == ST_IDLE};
        case (state)
            ST_IDLE:       begin pin_ale = 1'b1;     pin_psen = 1'b1;      end
            ST_PD, ST_STAB: begin pin_ale = 1'b0;    pin_psen = 1'b0;      end
            default:       begin pin_ale = core_ale; pin_psen = core_psen; end
        endcase
    end

    AST_IDLE_CPU_OFF: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode_bits == 2'b01) |-> !cpu_clk_en);  // R2
    AST_PD_CLOCKS_OFF: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode_bits == 2'b10) |-> (!osc_en && !periph_clk_en));  // R4
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
    localparam int STAB = 40;
    localparam int MCT  = 12;
    localparam int WIN  = 2;

    logic clk_in = 1'b0;
    logic rst_n = 1'b0;
    logic req_idle = 0, req_pd = 0, irq_int = 0, irq_ext = 0, hw_reset = 0;
    logic core_ale = 0, core_psen = 0;
    logic cpu_clk_en, periph_clk_en, osc_en, ram_wr_inhibit, sfr_reset, pin_ale, pin_psen;
    logic [1:0] mode_bits;
    int checks = 0;
    int errors = 0;

    always #5 clk_in = ~clk_in;

    lpm_ctrl #(.STAB_CYCLES(STAB), .MC_TICKS(MCT), .RST_WIN_MC(WIN)) u_dut (
        .clk_in(clk_in), .rst_n(rst_n), .req_idle(req_idle), .req_pd(req_pd),
        .irq_int(irq_int), .irq_ext(irq_ext), .hw_reset(hw_reset),
        .core_ale(core_ale), .core_psen(core_psen), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_en(osc_en), .ram_wr_inhibit(ram_wr_inhibit),
        .sfr_reset(sfr_reset), .pin_ale(pin_ale), .pin_psen(pin_psen), .mode_bits(mode_bits)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk_in);
    endtask

    task automatic t_reset_state();
        check("R1 reset mode", mode_bits, 0);
        check("R1 reset osc", osc_en, 1);
        check("R1 reset sfr", sfr_reset, 0);
    endtask

    task automatic t_divide();
        int highs = 0, alt_ok = 1;
        logic prev;
        prev = periph_clk_en;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (periph_clk_en == prev) alt_ok = 0;
            if (periph_clk_en) highs++;
            prev = periph_clk_en;
        end
        check("R1 alternation", alt_ok, 1);
        check("R1 high count", highs, 10);
    endtask

    task automatic t_idle(input bit use_ext);
        int cpu = 0, per = 0;
        core_ale = 0; core_psen = 1;
        req_idle = 1; step(1); req_idle = 0;
        check("R2 idle mode", mode_bits, 1);
        check("R8 idle pins", {pin_ale, pin_psen}, 3);
        for (int i = 0; i < 10; i++) begin
            if (cpu_clk_en) cpu++;
            if (periph_clk_en) per++;
            step(1);
        end
        check("R2 idle cpu off", cpu, 0);
        check("R2 idle periph on", per, 5);
        check("R2 idle osc", osc_en, 1);
        if (use_ext) irq_ext = 1; else irq_int = 1;
        step(1); irq_ext = 0; irq_int = 0;
        check("R3 idle wake", mode_bits, 0);
        check("R8 run pins", {pin_ale, pin_psen}, 1);
    endtask

    task automatic t_pd_ext();
        int settle = 0, osc_bad = 0, cpu = 0;
        core_ale = 1; core_psen = 0;
        req_pd = 1; req_idle = 1; step(1); req_pd = 0; req_idle = 0;
        check("R10 pd priority", mode_bits, 2);
        check("R4 pd osc", osc_en, 0);
        check("R8 pd pins", {pin_ale, pin_psen}, 0);
        step(1);
        check("R4 pd periph", periph_clk_en | cpu_clk_en, 0);
        irq_int = 1; step(1); irq_int = 0; step(3);
        check("R5 pd ignores int mode", mode_bits, 2);
        check("R5 pd ignores int osc", osc_en, 0);
        irq_ext = 1; step(1); irq_ext = 0;
        while (pin_ale == 0 && settle < 200) begin
            settle++;
            if (!osc_en) osc_bad++;
            if (cpu_clk_en) cpu++;
            step(1);
        end
        check("R6 settle length", settle, STAB);
        check("R6 osc during settle", osc_bad, 0);
        check("R6 cpu off in settle", cpu, 0);
        check("R10 bits clear", mode_bits, 0);
    endtask

    task automatic t_pd_reset();
        req_pd = 1; step(1); req_pd = 0;
        check("R4 pd entered", mode_bits, 2);
        hw_reset = 1; step(1);
        check("R7 pd reset mode", mode_bits, 0);
        check("R7 sfr pulse", sfr_reset, 1);
        step(1);
        check("R7 sfr one cycle", sfr_reset, 0);
        hw_reset = 0; step(2);
    endtask

    task automatic t_idle_reset();
        int both = 0, pulses = 0;
        req_idle = 1; step(1); req_idle = 0; step(3);
        hw_reset = 1;
        for (int i = 0; i < 80; i++) begin
            step(1);
            if (cpu_clk_en && ram_wr_inhibit) both++;
            if (sfr_reset) pulses++;
        end
        hw_reset = 0;
        check("R9 window ticks", both, WIN * MCT);
        check("R9 sfr pulses", pulses, 1);
        check("R9 inhibit off", ram_wr_inhibit, 0);
        check("R9 back to run", mode_bits, 0);
        step(2);
    endtask

    task automatic t_run_reset();
        int pulses = 0;
        hw_reset = 1;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (sfr_reset) pulses++;
        end
        hw_reset = 0; step(1);
        check("R11 run sfr pulses", pulses, 1);
        check("R11 stays run", mode_bits, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset_state();
        t_divide();
        t_idle(0);
        t_idle(1);
        t_pd_ext();
        t_pd_reset();
        t_idle_reset();
        t_run_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule